// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a 32-bit tick timer that sits in a processor's special-purpose register space. It holds two software-visible registers: a count register that advances once per clock, and a control register that carries a two-bit mode, a 28-bit match value, an interrupt-enable bit and a sticky interrupt-pending bit. Software reads and writes both registers through a plain register port: a write strobe, a one-bit register select, write data and a read-data bus that is decoded combinationally.

When the low 28 bits of the count equal the match value, the mode decides what happens. The count can wrap to zero and keep going, it can halt, or the comparison can be ignored and the count left to run freely. A match in the wrap or halt mode sets the pending bit if interrupts are enabled. The interrupt output is raised only while an external tick-exception-enable input is high. While that input is low the pending bit is kept, and the request appears as soon as the enable returns.

Top module: `tick_timer`

## Requirements
- R1: After reset both registers read zero and the interrupt output is low. The control register places the mode in bits 31:30, with 0 = off, 1 = wrap on match, 2 = halt on match and 3 = free run. The interrupt-enable bit is bit 29, the pending bit is bit 28, and the match value is bits 27:0.
- R2: In mode 0 the count holds its value.
- R3: In mode 3 the count rises by one each cycle and wraps from 0xFFFFFFFF to 0, and it never sets the pending bit.
- R4: In mode 1, a cycle in which count[27:0] equals the match value loads the count with zero. In every other mode-1 cycle the count rises by one.
- R5: In mode 2 the count rises by one until count[27:0] equals the match value. It then halts at that value until either register is written.
- R6: A match in mode 1 or mode 2 sets the pending bit on the following edge when bit 29 is 1, and leaves it unchanged when bit 29 is 0.
- R7: The interrupt output is high exactly when pending, interrupt-enable and the tick-exception-enable input are all 1. A pending request raised while that input is low is held until the input goes high.
- R8: The pending bit is sticky. Only a write to the control register with bit 28 at 0 clears it.
- R9: A write to the control register with mode 1 clears the count to zero on the same edge.
- R10: A write to the count register loads the written value, overrides the increment and any match action in that cycle, and releases a mode-2 halt. The next match is then reached from the new value.
- R11: A write to the control register with mode 0, 2 or 3 leaves the count unchanged and releases a mode-2 halt.
- R12: reg_rdata shows the count register when reg_sel is 0 and the control register, including the live pending bit, when reg_sel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 count, 1 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| tick_en | input | 1 | External tick-exception enable |
| tick_irq | output | 1 | Tick interrupt request |

## Verification
The bench drives a match value of zero and match values reached right after a write. An off-by-one compare would then stretch or shorten the wrap period, and a design that missed a halt would count past the match. It starts a count above 2^28 whose low bits already match, which exposes a design that compares all 32 bits. It holds tick_en low across a match and then raises it: a design that dropped the request would never assert the interrupt. It also checks that the pending bit survives later matches and clears only on an explicit write, and that a count write made while halted resumes counting instead of staying stuck.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic [1:0] {
    TM_OFF     = 2'd0,
    TM_RESTART = 2'd1,
    TM_STOP    = 2'd2,
    TM_FREE    = 2'd3
  } tick_mode_e;
endpackage

// File: rtl/tick_cnt.sv
module tick_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (clr)   cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tick_ctl_reg.sv
module tick_ctl_reg #(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             set_pend,
  output logic [CNT_W-1:0] ctl_q
);
  localparam int PEND_BIT = PER_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_q <= '0;
    else if (wr)       ctl_q <= wdata;
    else if (set_pend) ctl_q[PEND_BIT] <= 1'b1;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             tick_en,
  output logic             tick_irq
);
  import tick_pkg::*;

  localparam int MODE_HI  = CNT_W - 1;
  localparam int MODE_LO  = CNT_W - 2;
  localparam int PEND_BIT = PER_W;
  localparam int IE_BIT   = PER_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ctl_q;
  logic             halt_q;
  tick_mode_e       mode;
  tick_mode_e       wr_mode_val;
  logic             wr_cnt, wr_ctl, hit;
  logic             wrap_hit, stop_hit, inc, clr;

  assign mode        = tick_mode_e'(ctl_q[MODE_HI:MODE_LO]);
  assign wr_mode_val = tick_mode_e'(reg_wdata[MODE_HI:MODE_LO]);
  assign wr_cnt      = reg_we & ~reg_sel;
  assign wr_ctl      = reg_we & reg_sel;
  assign hit         = (cnt_q[PER_W-1:0] == ctl_q[PER_W-1:0]);

  // Any register write cancels the match action of its cycle.
  assign wrap_hit = !reg_we && (mode == TM_RESTART) && hit;
  assign stop_hit = !reg_we && (mode == TM_STOP) && hit && !halt_q;

  always_comb begin
    inc = 1'b0;
    if (!reg_we) begin
      unique case (mode)
        TM_FREE:    inc = 1'b1;
        TM_RESTART: inc = !hit;
        TM_STOP:    inc = !hit && !halt_q;
        default:    inc = 1'b0;
      endcase
    end
  end

  assign clr = wrap_hit || (wr_ctl && wr_mode_val == TM_RESTART);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halt_q <= 1'b0;
    else if (reg_we)   halt_q <= 1'b0;
    else if (stop_hit) halt_q <= 1'b1;
  end

  tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(wr_cnt), .load_val(reg_wdata),
    .clr(clr), .inc(inc), .cnt_q(cnt_q)
  );

  tick_ctl_reg #(.CNT_W(CNT_W), .PER_W(PER_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_ctl), .wdata(reg_wdata),
    .set_pend((wrap_hit || stop_hit) && ctl_q[IE_BIT]),
    .ctl_q(ctl_q)
  );

  assign reg_rdata = reg_sel ? ctl_q : cnt_q;
  assign tick_irq  = ctl_q[PEND_BIT] & ctl_q[IE_BIT] & tick_en;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             reg_sel,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             tick_en,
  input logic             tick_irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] ctl_q
);
  // R7
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> tick_en);

  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && ctl_q[CNT_W-1:CNT_W-2] == 2'd0) |=> $stable(cnt_q));

  // R3
  free_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && ctl_q[CNT_W-1:CNT_W-2] == 2'd3) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R10
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) |=> cnt_q == $past(reg_wdata));

  // R9
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel && reg_wdata[CNT_W-1:CNT_W-2] == 2'd1) |=> cnt_q == '0);

  // R8
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[PER_W] && !(reg_we && reg_sel)) |=> ctl_q[PER_W]);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .tick_en(tick_en), .tick_irq(tick_irq),
  .cnt_q(cnt_q), .ctl_q(ctl_q)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_en = 1'b0;
  logic        tick_irq;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0] m_cnt = '0;
  logic [31:0] m_ctl = '0;
  bit          m_halt = 1'b0;

  always #10 clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_en(tick_en), .tick_irq(tick_irq)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model_step(bit we, bit sel, logic [31:0] wd);
    int unsigned mode = m_ctl[31:30];
    bit match = (m_cnt[27:0] == m_ctl[27:0]);
    if (we) begin
      m_halt = 1'b0;
      if (!sel) m_cnt = wd;
      else begin
        m_ctl = wd;
        if (wd[31:30] == 2'd1) m_cnt = '0;
      end
    end else if (mode == 3) begin
      m_cnt = m_cnt + 1;
    end else if (mode == 1) begin
      if (match) begin
        m_cnt = '0;
        if (m_ctl[29]) m_ctl[28] = 1'b1;
      end else m_cnt = m_cnt + 1;
    end else if (mode == 2 && !m_halt) begin
      if (match) begin
        m_halt = 1'b1;
        if (m_ctl[29]) m_ctl[28] = 1'b1;
      end else m_cnt = m_cnt + 1;
    end
  endfunction

  // One clock: drive at negedge, compare both registers and irq after the edge.
  task automatic step(string req, bit we = 0, bit sel = 0, logic [31:0] wd = '0);
    @(negedge clk);
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    model_step(we, sel, wd);
    @(posedge clk);
    #2;
    reg_we = 1'b0;
    reg_sel = 1'b0; #1;
    check(req, "count", reg_rdata, m_cnt);
    reg_sel = 1'b1; #1;
    check(req, "control", reg_rdata, m_ctl);
    check(req, "irq", {31'd0, tick_irq}, {31'd0, m_ctl[28] & m_ctl[29] & tick_en});
  endtask

  task automatic run(string req, int n);
    for (int i = 0; i < n; i++) step(req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #5;
    reg_sel = 1'b0; #1;
    check("R1", "reset count", reg_rdata, 32'h0);
    check("R1", "reset irq", {31'd0, tick_irq}, 32'h0);
    #30 rst_n = 1'b1;

    // R2 / R12: mode off holds, count write then hold
    run("R2", 3);
    step("R10", 1, 0, 32'h0000_0005);
    run("R2", 4);

    // R3: free run wrap, no pending even with ie and match value
    step("R11", 1, 1, {2'd3, 1'b1, 1'b0, 28'h0000001});
    step("R10", 1, 0, 32'hFFFF_FFFE);
    run("R3", 5);

    // R4 / R6 / R7 / R9: wrap mode, period 3, ie set, tick_en low
    tick_en = 1'b0;
    step("R9", 1, 1, {2'd1, 1'b1, 1'b0, 28'd3});
    run("R4", 10);
    run("R7", 2);
    tick_en = 1'b1;
    run("R7", 3);
    // R8: clear pending by write with bit28 = 0
    step("R8", 1, 1, {2'd1, 1'b1, 1'b0, 28'd3});
    run("R8", 2);
    // period zero wraps every cycle
    step("R4", 1, 1, {2'd1, 1'b1, 1'b0, 28'd0});
    run("R4", 4);

    // R6: ie clear, no pending
    step("R6", 1, 1, {2'd1, 1'b0, 1'b0, 28'd2});
    run("R6", 8);

    // R5: halt mode
    step("R11", 1, 0, 32'd0);
    step("R5", 1, 1, {2'd2, 1'b1, 1'b0, 28'd4});
    run("R5", 10);
    // R10: count write releases halt
    step("R10", 1, 0, 32'd1);
    run("R10", 6);
    // R8: pending survives while halted, then cleared by write
    step("R8", 1, 1, {2'd2, 1'b1, 1'b0, 28'd6});
    run("R5", 8);

    // R4/R5 compare only low 28 bits
    step("R10", 1, 0, 32'h1000_0002);
    step("R11", 1, 1, {2'd2, 1'b1, 1'b0, 28'd2});
    run("R5", 3);

    // R11: mode writes keep count
    step("R11", 1, 1, {2'd0, 1'b0, 1'b0, 28'd9});
    run("R11", 2);
    step("R11", 1, 1, {2'd3, 1'b0, 1'b0, 28'd9});
    run("R11", 2);

    // R12: live pending visible, irq tracks tick_en
    step("R12", 1, 1, {2'd1, 1'b1, 1'b0, 28'd1});
    run("R12", 3);
    tick_en = 1'b0;
    run("R7", 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule